// File: doc/BRIEF.md
# Strided Image Line DMA Engine

This engine copies a rectangular window of a raster image between a byte-addressed image memory and a streaming device port, one line at a time. Software supplies four values: a 24-bit start address, the number of bytes to move from each line, the page width in bytes, and the number of lines. The page width is kept apart from the byte count. Each new line therefore begins one page width after the start of the previous line, and the engine can pull a narrow column out of a wider page or write one back into it.

The memory side is a simple strobe bus. It can be 8 or 16 bits wide and has one enable per byte lane. The mode is picked per transfer. Before any memory cycle the engine asks an external arbiter for the bus and waits for a grant. It keeps the request up until the last unit has moved. On the device side, each unit waits for `dev_req`, and each finished unit is confirmed with a one-cycle `dev_ack`. The transfer ends with a one-cycle `done` strobe and a sticky `irq`.

Top module: `strided_line_dma`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `bus_req`, `mem_rd`, `mem_wr`, `mem_lbe`, `mem_ube`, `dev_ack`, `done` and `irq` are all 0.
- R2: `bus_req` goes high in the cycle after `go` is accepted. `mem_rd` and `mem_wr` are only ever high while `bus_gnt` is high. `bus_req` is low in the cycle where `done` is high.
- R3: Line k (counting from 0) begins at `cfg_start + k*cfg_doc_width`, modulo 2^24. Inside a line, each memory cycle starts at the byte just after the last byte of the previous cycle.
- R4: With `cfg_wide`=0, every memory cycle moves one byte at `mem_addr`, with `mem_lbe`=1 and `mem_ube`=0, on data bits 7:0.
- R5: With `cfg_wide`=1, bits 7:0 carry the even byte and bits 15:8 the odd byte. An odd address gives a one-byte cycle with only `mem_ube`. An even address with at least two bytes left in the line gives a two-byte cycle with both enables. An even address with one byte left gives a one-byte cycle with only `mem_lbe`.
- R6: Each line moves exactly `cfg_line_bytes` bytes (1 to 8192), and there are exactly `cfg_lines` lines (1 to 65536).
- R7: With `cfg_to_mem`=0, every memory read is followed by exactly one `dev_ack` cycle. In that cycle `dev_dout` holds the enabled lanes of `mem_rdata` and zero in the disabled lanes. `dev_ack` is never high in the same cycle as a memory strobe.
- R8: With `cfg_to_mem`=1, `dev_din` is sampled in the cycle where `dev_req` is seen high. It is written to memory on the enabled lanes only. Bytes outside the window, including the gap between lines, are left unchanged.
- R9: `done` is high for exactly one cycle after the last unit. `irq` goes high in that same cycle and stays high until the next `go` is accepted.
- R10: A `go` that arrives while a transfer is running is ignored. The running transfer keeps its own settings, and no second transfer follows.
- R11: While `mem_rdy` is low, the active strobe and `mem_addr` stay where they are. Each memory cycle lasts until `mem_rdy` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse, accepted only when idle |
| cfg_start | input | 24 | First byte address of the window |
| cfg_line_bytes | input | 14 | Bytes moved per line (1 to 8192) |
| cfg_doc_width | input | 14 | Address step from one line start to the next |
| cfg_lines | input | 17 | Number of lines (1 to 65536) |
| cfg_wide | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| cfg_to_mem | input | 1 | 1 writes device data to memory, 0 reads memory to the device |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_lbe | output | 1 | Lower byte lane (bits 7:0) enable |
| mem_ube | output | 1 | Upper byte lane (bits 15:8) enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rdy | input | 1 | Memory cycle completes when high |
| dev_req | input | 1 | Device ready for the next unit |
| dev_ack | output | 1 | One-cycle unit acknowledge to the device |
| dev_din | input | 16 | Data from the device (write direction) |
| dev_dout | output | 16 | Data to the device (read direction) |
| done | output | 1 | One-cycle end-of-transfer strobe |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench builds the engine with its default parameters: a 24-bit address, 14-bit line and stride fields, and a 17-bit line count. Its memory model decodes only the low 12 address bits. With these values, windows of a few bytes on a page a few dozen bytes wide already reach the interesting cases: odd start addresses, odd line lengths, line starts that alternate between even and odd, gaps between lines that must not be touched, and one-byte windows. Scenarios also add memory wait states, a grant that arrives late or is withdrawn in the middle of a transfer, and a second start pulse while the engine is busy.

// File: rtl/sdma_pkg.sv
// sdma_pkg: types and constants shared by the strided line DMA modules.
// Assumes a memory data bus of at most two byte lanes.
package sdma_pkg;

    localparam int BUS_W     = 16;
    localparam int BUS_LANES = BUS_W / 8;

    // Sequencer states; order has no meaning outside the sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_DEV,
        ST_MEM,
        ST_ACK,
        ST_DONE
    } sdma_state_e;

    // Byte count and lane enables of the next memory cycle.
    typedef struct packed {
        logic [1:0] unit;
        logic       lbe;
        logic       ube;
    } lane_plan_t;

endpackage

// File: rtl/sdma_lane_sel.sv
// sdma_lane_sel: works out the size and byte-lane enables of the next
// memory cycle from the current address parity, the bytes left in the
// line and the bus mode. Purely combinational.
// Assumes bytes_left is never zero while a cycle is pending.
module sdma_lane_sel
    import sdma_pkg::*;
#(
    parameter int LBW = 14
) (
    input  logic           wide,
    input  logic           addr_lsb,
    input  logic [LBW-1:0] bytes_left,
    output lane_plan_t     plan
);

    localparam logic [LBW-1:0] TWO = LBW'(2);

    // Pick the unit: one byte in 8-bit mode or on odd/final bytes, else a word.
    always_comb begin
        plan.unit = 2'd1;
        plan.lbe  = 1'b1;
        plan.ube  = 1'b0;
        if (wide) begin
            if (addr_lsb) begin
                plan.lbe = 1'b0;
                plan.ube = 1'b1;
            end else if (bytes_left >= TWO) begin
                plan.unit = 2'd2;
                plan.ube  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdma_addr_gen.sv
// sdma_addr_gen: keeps the current byte address, the bytes left in the
// current line and the lines still to go. At each line end the next address
// is the stored line base plus the stride, not the running address.
// Assumes unit never exceeds bytes_left (guaranteed by sdma_lane_sel).
module sdma_addr_gen #(
    parameter int AW  = 24,
    parameter int LBW = 14,
    parameter int LCW = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [1:0]     unit,
    input  logic [AW-1:0]  start_addr,
    input  logic [LBW-1:0] line_bytes,
    input  logic [LBW-1:0] stride,
    input  logic [LCW-1:0] line_total,
    output logic [AW-1:0]  cur_addr,
    output logic [LBW-1:0] bytes_left,
    output logic           finished
);

    localparam int PADW = AW - LBW;

    logic [AW-1:0]  line_base;
    logic [AW-1:0]  next_base;
    logic [AW-1:0]  stride_ext;
    logic [AW-1:0]  unit_addr;
    logic [LBW-1:0] line_len;
    logic [LBW-1:0] stride_q;
    logic [LBW-1:0] unit_cnt;
    logic [LCW-1:0] lines_left;
    logic           line_end;

    assign stride_ext = {{PADW{1'b0}}, stride_q};
    assign unit_addr  = {{(AW-2){1'b0}}, unit};
    assign unit_cnt   = {{(LBW-2){1'b0}}, unit};
    assign next_base  = line_base + stride_ext;
    assign line_end   = (bytes_left == unit_cnt);
    assign finished   = (lines_left == '0);

    // Latch the settings on load, then advance by unit or jump by stride.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base  <= '0;
            cur_addr   <= '0;
            bytes_left <= '0;
            line_len   <= '0;
            stride_q   <= '0;
            lines_left <= '0;
        end else if (load) begin
            line_base  <= start_addr;
            cur_addr   <= start_addr;
            bytes_left <= line_bytes;
            line_len   <= line_bytes;
            stride_q   <= stride;
            lines_left <= line_total;
        end else if (step) begin
            if (line_end) begin
                line_base  <= next_base;
                cur_addr   <= next_base;
                bytes_left <= line_len;
                lines_left <= lines_left - LCW'(1);
            end else begin
                cur_addr   <= cur_addr + unit_addr;
                bytes_left <= bytes_left - unit_cnt;
            end
        end
    end

endmodule

// File: rtl/sdma_lanes.sv
// sdma_lanes: per-byte-lane data registers. Captures device data for writes
// and enabled memory lanes for reads; disabled read lanes are cleared.
// Assumes the capture strobes come from the sequencer.
module sdma_lanes
    import sdma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_din,
    input  logic                 cap_rd,
    input  logic [BUS_LANES-1:0] lane_en,
    input  logic [BUS_W-1:0]     mem_rdata,
    input  logic [BUS_W-1:0]     dev_din,
    output logic [BUS_W-1:0]     dev_dout,
    output logic [BUS_W-1:0]     mem_wdata
);

    for (genvar g = 0; g < BUS_LANES; g++) begin : g_lane
        logic [7:0] rd_q;
        logic [7:0] wr_q;

        // Hold one read byte for the device, zero when the lane is unused.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_q <= 8'h00;
            else if (cap_rd)
                rd_q <= lane_en[g] ? mem_rdata[g*8 +: 8] : 8'h00;
        end

        // Hold one write byte taken from the device.
        always_ff @(posedge clk) begin
            if (!rst_n)
                wr_q <= 8'h00;
            else if (cap_din)
                wr_q <= dev_din[g*8 +: 8];
        end

        assign dev_dout[g*8 +: 8]  = rd_q;
        assign mem_wdata[g*8 +: 8] = wr_q;
    end

endmodule

// File: rtl/sdma_seq.sv
// sdma_seq: transfer sequencer. Takes the bus, then runs a
// device-wait / memory-cycle / acknowledge loop for each unit and ends with
// a done strobe and a sticky interrupt.
// Assumes `finished` from the address generator is valid in ST_ACK.
module sdma_seq
    import sdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic bus_gnt,
    input  logic dev_req,
    input  logic mem_rdy,
    input  logic finished,
    output logic load,
    output logic step,
    output logic cap_din,
    output logic mem_cyc,
    output logic bus_req,
    output logic dev_ack,
    output logic done,
    output logic irq
);

    sdma_state_e state, state_nx;

    // Next-state selection for the per-unit loop.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go) state_nx = ST_ARB;
            ST_ARB:  if (bus_gnt) state_nx = ST_DEV;
            ST_DEV:  if (dev_req) state_nx = ST_MEM;
            ST_MEM:  if (bus_gnt && mem_rdy) state_nx = ST_ACK;
            ST_ACK:  state_nx = finished ? ST_DONE : ST_DEV;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Interrupt: set when the last unit is acknowledged, cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (state == ST_ACK && finished)
            irq <= 1'b1;
        else if (state == ST_IDLE && go)
            irq <= 1'b0;
    end

    assign load    = (state == ST_IDLE) && go;
    assign cap_din = (state == ST_DEV) && dev_req;
    assign mem_cyc = (state == ST_MEM) && bus_gnt;
    assign step    = mem_cyc && mem_rdy;
    assign dev_ack = (state == ST_ACK);
    assign done    = (state == ST_DONE);
    assign bus_req = (state == ST_ARB) || (state == ST_DEV) ||
                     (state == ST_MEM) || (state == ST_ACK);

endmodule

// File: rtl/strided_line_dma.sv
// strided_line_dma: top level of the strided line DMA engine. Latches the
// bus mode and direction at start, connects the sequencer, address
// generator, lane selector and lane registers, and gates the strobes.
// Assumes the cfg_* inputs are stable in the cycle go is high.
module strided_line_dma
    import sdma_pkg::*;
#(
    parameter int AW  = 24,
    parameter int LBW = 14,
    parameter int LCW = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [AW-1:0]    cfg_start,
    input  logic [LBW-1:0]   cfg_line_bytes,
    input  logic [LBW-1:0]   cfg_doc_width,
    input  logic [LCW-1:0]   cfg_lines,
    input  logic             cfg_wide,
    input  logic             cfg_to_mem,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             mem_lbe,
    output logic             mem_ube,
    output logic [BUS_W-1:0] mem_wdata,
    input  logic [BUS_W-1:0] mem_rdata,
    input  logic             mem_rdy,
    input  logic             dev_req,
    output logic             dev_ack,
    input  logic [BUS_W-1:0] dev_din,
    output logic [BUS_W-1:0] dev_dout,
    output logic             done,
    output logic             irq
);

    logic           load;
    logic           step;
    logic           cap_din;
    logic           mem_cyc;
    logic           finished;
    logic           wide_q;
    logic           to_mem_q;
    logic [LBW-1:0] bytes_left;
    lane_plan_t     plan;

    // Keep bus mode and direction fixed for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q   <= 1'b0;
            to_mem_q <= 1'b0;
        end else if (load) begin
            wide_q   <= cfg_wide;
            to_mem_q <= cfg_to_mem;
        end
    end

    sdma_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .bus_gnt  (bus_gnt),
        .dev_req  (dev_req),
        .mem_rdy  (mem_rdy),
        .finished (finished),
        .load     (load),
        .step     (step),
        .cap_din  (cap_din),
        .mem_cyc  (mem_cyc),
        .bus_req  (bus_req),
        .dev_ack  (dev_ack),
        .done     (done),
        .irq      (irq)
    );

    sdma_addr_gen #(
        .AW  (AW),
        .LBW (LBW),
        .LCW (LCW)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .unit       (plan.unit),
        .start_addr (cfg_start),
        .line_bytes (cfg_line_bytes),
        .stride     (cfg_doc_width),
        .line_total (cfg_lines),
        .cur_addr   (mem_addr),
        .bytes_left (bytes_left),
        .finished   (finished)
    );

    sdma_lane_sel #(
        .LBW (LBW)
    ) u_lane_sel (
        .wide       (wide_q),
        .addr_lsb   (mem_addr[0]),
        .bytes_left (bytes_left),
        .plan       (plan)
    );

    sdma_lanes u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_din   (cap_din),
        .cap_rd    (step),
        .lane_en   ({plan.ube, plan.lbe}),
        .mem_rdata (mem_rdata),
        .dev_din   (dev_din),
        .dev_dout  (dev_dout),
        .mem_wdata (mem_wdata)
    );

    assign mem_rd  = mem_cyc && !to_mem_q;
    assign mem_wr  = mem_cyc && to_mem_q;
    assign mem_lbe = mem_cyc && plan.lbe;
    assign mem_ube = mem_cyc && plan.ube;

endmodule

// File: rtl/sdma_checker.sv
// sdma_checker: protocol properties of strided_line_dma, bound to the top.
// Assumes a synchronous active-low reset on rst_n.
module sdma_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          mem_lbe,
    input logic          mem_ube,
    input logic          mem_rdy,
    input logic          dev_ack,
    input logic          done,
    input logic          irq,
    input logic          wide_q
);

    a_r2_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (bus_req && bus_gnt));

    a_r2_bus_free_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    a_r4_byte_mode_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !wide_q) |-> (mem_lbe && !mem_ube));

    a_r5_odd_upper_lane: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && wide_q && mem_addr[0]) |-> (mem_ube && !mem_lbe));

    a_r7_ack_apart_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> !(mem_rd || mem_wr));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> irq);

    a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_rdy) |=> $stable(mem_addr));

    a_r11_no_read_write_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind strided_line_dma sdma_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_lbe  (mem_lbe),
    .mem_ube  (mem_ube),
    .mem_rdy  (mem_rdy),
    .dev_ack  (dev_ack),
    .done     (done),
    .irq      (irq),
    .wide_q   (wide_q)
);

// File: tb/strided_line_dma_tb_top.sv
// Directed bench for strided_line_dma: a memory model with wait states, a
// grant model and a device model; one task for each scenario.
module strided_line_dma_tb_top;

    localparam int CLK_P = 10;
    localparam int MAXU  = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [23:0] cfg_start = '0;
    logic [13:0] cfg_line_bytes = '0;
    logic [13:0] cfg_doc_width = '0;
    logic [16:0] cfg_lines = '0;
    logic        cfg_wide = 1'b0;
    logic        cfg_to_mem = 1'b0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, mem_lbe, mem_ube;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rdy;
    logic        dev_req = 1'b1;
    logic        dev_ack;
    logic [15:0] dev_din;
    logic [15:0] dev_dout;
    logic        done, irq;

    always #(CLK_P/2) clk = ~clk;

    strided_line_dma dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg_start(cfg_start),
        .cfg_line_bytes(cfg_line_bytes), .cfg_doc_width(cfg_doc_width),
        .cfg_lines(cfg_lines), .cfg_wide(cfg_wide), .cfg_to_mem(cfg_to_mem),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_lbe(mem_lbe), .mem_ube(mem_ube),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_din(dev_din),
        .dev_dout(dev_dout), .done(done), .irq(irq)
    );

    // ---------------- models ----------------
    logic [7:0]  mem [4096];
    logic [7:0]  exp_mem [4096];
    int          ws_cfg = 0, ws_cnt = 0;
    int          gnt_dly = 0, gcyc = 0;
    bit          drop_en = 0;
    bit          wide_m = 0;
    int          pcnt = 0;

    assign mem_rdy = (ws_cnt >= ws_cfg);
    assign dev_din = {pcnt[7:0] ^ 8'hA0, pcnt[7:0]};

    always_comb begin
        if (wide_m)
            mem_rdata = {mem[{mem_addr[11:1], 1'b1}], mem[{mem_addr[11:1], 1'b0}]};
        else
            mem_rdata = {8'h00, mem[mem_addr[11:0]]};
    end

    always @(posedge clk) begin
        if ((mem_rd || mem_wr) && !mem_rdy) ws_cnt <= ws_cnt + 1;
        else ws_cnt <= 0;
        if (mem_wr && mem_rdy) begin
            if (!wide_m) mem[mem_addr[11:0]] <= mem_wdata[7:0];
            else begin
                if (mem_lbe) mem[{mem_addr[11:1], 1'b0}] <= mem_wdata[7:0];
                if (mem_ube) mem[{mem_addr[11:1], 1'b1}] <= mem_wdata[15:8];
            end
        end
        if (dev_ack) pcnt <= pcnt + 1;
        if (!bus_req) begin
            gcyc    <= 0;
            bus_gnt <= 1'b0;
        end else begin
            gcyc    <= gcyc + 1;
            bus_gnt <= (gcyc >= gnt_dly) &&
                       !(drop_en && gcyc >= gnt_dly + 6 && gcyc < gnt_dly + 10);
        end
    end

    // ---------------- monitor (away from the active edge) ----------------
    int          log_n, ack_n, done_n, viol_n, strobe_n;
    logic [23:0] log_addr [MAXU];
    logic [1:0]  log_en   [MAXU];
    logic [15:0] ack_data [MAXU];

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd || mem_wr) begin
                strobe_n++;
                if (!bus_gnt) viol_n++;
                if (mem_rdy && log_n < MAXU) begin
                    log_addr[log_n] = mem_addr;
                    log_en[log_n]   = {mem_ube, mem_lbe};
                    log_n++;
                end
            end
            if (dev_ack && ack_n < MAXU) begin
                ack_data[ack_n] = dev_dout;
                ack_n++;
            end
            if (done) done_n++;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_err = 0;
    int          exp_n;
    logic [23:0] exp_addr [MAXU];
    logic [1:0]  exp_en   [MAXU];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Expected cycle list from R3, R4, R5, R6.
    task automatic build_exp(input int st, input int lb, input int doc,
                             input int nl, input bit wd);
        exp_n = 0;
        for (int l = 0; l < nl; l++) begin
            int off = 0;
            while (off < lb) begin
                logic [23:0] a;
                a = 24'(st + l * doc + off);
                exp_addr[exp_n] = a;
                if (!wd)                 begin exp_en[exp_n] = 2'b01; off += 1; end
                else if (a[0])           begin exp_en[exp_n] = 2'b10; off += 1; end
                else if (lb - off >= 2)  begin exp_en[exp_n] = 2'b11; off += 2; end
                else                     begin exp_en[exp_n] = 2'b01; off += 1; end
                exp_n++;
            end
        end
    endtask

    // Runs one transfer; optionally pulses go again while busy (R10).
    task automatic run_xfer(input int st, input int lb, input int doc,
                            input int nl, input bit wd, input bit tm,
                            input bit poke);
        int t = 0;
        build_exp(st, lb, doc, nl, wd);
        @(negedge clk);
        log_n = 0; ack_n = 0; done_n = 0; viol_n = 0; strobe_n = 0; pcnt = 0;
        cfg_start = 24'(st); cfg_line_bytes = 14'(lb); cfg_doc_width = 14'(doc);
        cfg_lines = 17'(nl); cfg_wide = wd; cfg_to_mem = tm; wide_m = wd;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(irq == 1'b0, "R9", "irq cleared by go", irq, 0);
        chk(bus_req == 1'b1, "R2", "bus_req after go", bus_req, 1);
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (poke && t == 8) begin
                go = 1'b1; cfg_start = 24'h800; cfg_line_bytes = 14'd2;
                cfg_lines = 17'd9; cfg_wide = ~wd;
            end else go = 1'b0;
        end
        chk(done == 1'b1, "R9", "done seen before timeout", done, 1);
        chk(bus_req == 1'b0, "R2", "bus_req low at done", bus_req, 0);
        chk(irq == 1'b1, "R9", "irq with done", irq, 1);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", done, 0);
        chk(irq == 1'b1, "R9", "irq held", irq, 1);
        repeat (12) @(negedge clk);
        chk(done_n == 1, "R10", "done pulses", done_n, 1);
        chk(bus_req == 1'b0, "R10", "no second transfer", bus_req, 0);
        chk(viol_n == 0, "R2", "strobes without grant", viol_n, 0);
        chk(log_n == exp_n, "R6", "memory cycle count", log_n, exp_n);
        chk(ack_n == exp_n, "R7", "ack count", ack_n, exp_n);
    endtask

    task automatic cmp_cycles(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (log_addr[i] !== exp_addr[i] || log_en[i] !== exp_en[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first >= 0)
            chk(0, req, "first bad cycle addr/en",
                {log_addr[first], 6'b0, log_en[first]}, {exp_addr[first], 6'b0, exp_en[first]});
        else
            chk(1, req, "cycle sequence", 0, 0);
    endtask

    task automatic cmp_read_data(input string req);
        int bad = 0;
        logic [15:0] e, fa;
        for (int i = 0; i < exp_n && i < ack_n; i++) begin
            logic [11:0] a;
            a = exp_addr[i][11:0];
            e = '0;
            if (!wide_m) e[7:0] = mem[a];
            else begin
                if (exp_en[i][0]) e[7:0]  = mem[{a[11:1], 1'b0}];
                if (exp_en[i][1]) e[15:8] = mem[{a[11:1], 1'b1}];
            end
            if (ack_data[i] !== e && bad == 0) begin
                fa = ack_data[i];
                chk(0, req, "dev_dout", fa, e);
            end
            if (ack_data[i] !== e) bad++;
        end
        if (bad == 0) chk(1, req, "dev_dout", 0, 0);
    endtask

    task automatic fill_read_pattern();
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
    endtask

    task automatic fill_write_bg();
        for (int i = 0; i < 4096; i++) begin mem[i] = 8'hEE; exp_mem[i] = 8'hEE; end
    endtask

    task automatic cmp_write(input string req);
        int bad = 0;
        for (int i = 0; i < exp_n; i++) begin
            logic [11:0] a;
            a = exp_addr[i][11:0];
            if (!wide_m) exp_mem[a] = 8'(i);
            else begin
                if (exp_en[i][0]) exp_mem[{a[11:1], 1'b0}] = 8'(i);
                if (exp_en[i][1]) exp_mem[{a[11:1], 1'b1}] = 8'(i) ^ 8'hA0;
            end
        end
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== exp_mem[i]) begin
                if (bad == 0) chk(0, req, $sformatf("byte at %0h", i), mem[i], exp_mem[i]);
                bad++;
            end
        if (bad == 0) chk(1, req, "memory image", 0, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();   // R1
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({bus_req, mem_rd, mem_wr, mem_lbe, mem_ube, dev_ack, done, irq} == 8'h00,
            "R1", "outputs in reset", {bus_req, mem_rd, mem_wr, mem_lbe, mem_ube, dev_ack, done, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bus_req, mem_rd, mem_wr, dev_ack, done, irq} == 6'h00,
            "R1", "outputs after reset", {bus_req, mem_rd, mem_wr, dev_ack, done, irq}, 0);
    endtask

    task automatic t_read_byte_stride();   // R3 R4 R6 R7
        ws_cfg = 0; gnt_dly = 0; drop_en = 0;
        fill_read_pattern();
        run_xfer(100, 5, 16, 3, 0, 0, 0);
        cmp_cycles("R3/R4");
        cmp_read_data("R7");
    endtask

    task automatic t_read_wide_odd_start();   // R5 R11
        ws_cfg = 2; gnt_dly = 1; drop_en = 0;
        fill_read_pattern();
        run_xfer(24'h201, 6, 20, 2, 1, 0, 0);
        cmp_cycles("R5");
        cmp_read_data("R7");
        chk(strobe_n == exp_n * 3, "R11", "strobe cycles with 2 wait states", strobe_n, exp_n * 3);
    endtask

    task automatic t_read_wide_odd_len();   // R5 R6
        ws_cfg = 0; gnt_dly = 0; drop_en = 0;
        fill_read_pattern();
        run_xfer(24'h300, 5, 9, 4, 1, 0, 0);
        cmp_cycles("R5/R6");
        cmp_read_data("R7");
    endtask

    task automatic t_single_byte();   // R5 R6 boundary: one byte, one line
        ws_cfg = 1; gnt_dly = 0; drop_en = 0;
        fill_read_pattern();
        run_xfer(24'h7FF, 1, 1, 1, 1, 0, 0);
        cmp_cycles("R5");
        cmp_read_data("R7");
    endtask

    task automatic t_write_wide();   // R8
        ws_cfg = 1; gnt_dly = 0; drop_en = 0;
        fill_write_bg();
        run_xfer(24'h400, 7, 12, 3, 1, 1, 0);
        cmp_cycles("R8/R3");
        cmp_write("R8");
    endtask

    task automatic t_write_byte();   // R8 R4
        ws_cfg = 0; gnt_dly = 0; drop_en = 0;
        fill_write_bg();
        run_xfer(24'h905, 3, 10, 3, 0, 1, 0);
        cmp_cycles("R4");
        cmp_write("R8");
    endtask

    task automatic t_grant_late_and_dropped();   // R2
        ws_cfg = 0; gnt_dly = 5; drop_en = 1;
        fill_read_pattern();
        run_xfer(24'h510, 8, 24, 2, 1, 0, 0);
        cmp_cycles("R2");
        cmp_read_data("R2");
    endtask

    task automatic t_go_while_busy();   // R10
        ws_cfg = 0; gnt_dly = 0; drop_en = 0;
        fill_read_pattern();
        run_xfer(24'h0C3, 4, 30, 3, 1, 0, 1);
        cmp_cycles("R10");
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_read_byte_stride();
        t_read_wide_odd_start();
        t_read_wide_odd_len();
        t_single_byte();
        t_write_wide();
        t_write_byte();
        t_grant_late_and_dropped();
        t_go_while_busy();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule